// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This block sits between an integer core and a 32-bit data memory that is addressed by whole words. It computes the effective address of a memory instruction, from the base register plus a 12-bit signed offset. It then turns a byte, halfword or word access into the form the memory understands. For a write, that is a word-aligned address, four per-byte write strobes and write data with the stored value copied into every lane it may land in. For a read, the memory returns the full word one cycle after the request. The block selects the addressed lane and widens it to 32 bits, with sign or zero fill as the access kind requires.

Accesses whose address does not suit their size are reported on a flag in the request cycle. Such accesses never reach the memory. The core supplies the instruction fields the block needs directly: the major opcode, the 3-bit width selector, and the offset fields in the two positions the instruction encodings use.

Top module: `lsu_lane_unit`

## Requirements
- R1: An access is issued only when `reqValid` is high and `opcode` is 7'b0000011 (read) or 7'b0100011 (write). Any other opcode, or `reqValid` low, leaves `memRe`, `memWe` and `misaligned` low. `memRe` and `memWe` are never high together.
- R2: The effective address is `rs1Val` plus the sign-extended 12-bit offset. For reads the offset is {`immHi`,`immLoadLo`}; for writes it is {`immHi`,`immStoreLo`}, and the unused low field has no effect. `memAddr` is the effective address with bits 1:0 cleared, and lane 0 is the least significant byte.
- R3: On a write, `memBe` is 4'b0001 shifted left by address bits 1:0 for `funct3`=0 (byte). It is 4'b0011 at offset 0 or 4'b1100 at offset 2 for `funct3`=1 (halfword), and 4'b1111 for `funct3`=2 (word).
- R4: On a write, `memWdata` holds `rs2Val[7:0]` in all four lanes for a byte, `rs2Val[15:0]` in both halves for a halfword, and `rs2Val` for a word. Without a write, `memBe` and `memWdata` are zero.
- R5: A halfword access with address bit 0 set, or a word access with either of bits 1:0 set, raises `misaligned` in that cycle. It raises neither `memRe` nor `memWe`, and it produces no `loadValid` in the next cycle.
- R6: `loadValid` rises exactly one cycle after a cycle with `memRe` high. The result is formed from the `memRdata` presented in that later cycle, using the lane bits and width captured with the request. Back-to-back reads each use their own captured values.
- R7: For a read, `funct3`=0 returns the addressed byte sign-extended, `funct3`=1 returns the addressed halfword sign-extended, and `funct3`=2 returns the word unchanged.
- R8: For a read, `funct3`=4 returns the addressed byte zero-extended, and `funct3`=5 returns the addressed halfword zero-extended.
- R9: A read with `funct3` of 3, 6 or 7, or a write with `funct3` of 3 to 7, issues no access and does not raise `misaligned`.
- R10: After reset, and in any cycle without `loadValid`, `loadData` is zero and `loadValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request qualifier for the instruction fields |
| opcode | input | 7 | Major opcode of the instruction |
| funct3 | input | 3 | Width and signedness selector |
| immHi | input | 7 | Offset bits 11:5 |
| immLoadLo | input | 5 | Offset bits 4:0 as placed in read instructions |
| immStoreLo | input | 5 | Offset bits 4:0 as placed in write instructions |
| rs1Val | input | 32 | Base register value |
| rs2Val | input | 32 | Value to be written |
| memRdata | input | 32 | Word returned by memory one cycle after a read |
| memAddr | output | 32 | Word-aligned memory address |
| memRe | output | 1 | Memory read request |
| memWe | output | 1 | Memory write request |
| memBe | output | 4 | Per-byte write strobes |
| memWdata | output | 32 | Lane-replicated write data |
| misaligned | output | 1 | Address does not suit the access width |
| loadValid | output | 1 | Read result valid |
| loadData | output | 32 | Extracted and extended read result |

## Verification
The hardest case to reach from the ports is two reads on consecutive cycles with different lanes and widths. In that case, the second request's lane bits are captured in the same edge at which the first result is formed. A slip by one cycle in the capture register would give a plausible but wrong byte. The bench reaches this case by presenting a new read in the very cycle in which it supplies the previous read's memory word, with distinct byte values in every lane. Each result can then come from only one lane. Negative offsets that borrow across the word boundary are covered as well. So are misaligned accesses, which must also leave no trailing `loadValid`.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } accSize_e;

  typedef struct packed {
    logic     doLoad;
    logic     doStore;
    logic     misalign;
    accSize_e size;
    logic     zeroExt;
  } laneCtrl_t;

endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic              reqValid,
  input  logic [6:0]        opcode,
  input  logic [2:0]        funct3,
  input  logic [LANE_W-1:0] addrLow,
  output logic              immSelStore,
  output laneCtrl_t         ctrl
);

  logic     isLoad;
  logic     isStore;
  accSize_e ldSize;
  accSize_e stSize;
  accSize_e reqSize;
  logic     legal;
  logic     badAlign;

  assign isLoad      = reqValid && (opcode == OPC_LOAD);
  assign isStore     = reqValid && (opcode == OPC_STORE);
  assign immSelStore = (opcode == OPC_STORE);

  always_comb begin
    ldSize = SZ_NONE;
    unique case (funct3)
      3'b000, 3'b100: ldSize = SZ_BYTE;
      3'b001, 3'b101: ldSize = SZ_HALF;
      3'b010:         ldSize = SZ_WORD;
      default:        ldSize = SZ_NONE;
    endcase
  end

  always_comb begin
    stSize = SZ_NONE;
    unique case (funct3)
      3'b000:  stSize = SZ_BYTE;
      3'b001:  stSize = SZ_HALF;
      3'b010:  stSize = SZ_WORD;
      default: stSize = SZ_NONE;
    endcase
  end

  assign reqSize = isStore ? stSize : ldSize;
  assign legal   = (isLoad || isStore) && (reqSize != SZ_NONE);

  always_comb begin
    badAlign = 1'b0;
    if (reqSize == SZ_HALF) badAlign = addrLow[0];
    else if (reqSize == SZ_WORD) badAlign = |addrLow;
  end

  always_comb begin
    ctrl.doLoad   = isLoad && legal && !badAlign;
    ctrl.doStore  = isStore && legal && !badAlign;
    ctrl.misalign = legal && badAlign;
    ctrl.size     = legal ? reqSize : SZ_NONE;
    ctrl.zeroExt  = funct3[2];
  end

endmodule

// File: rtl/lsu_lane_datapath.sv
module lsu_lane_datapath
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtrl_t         ctrl,
  input  logic              immSelStore,
  input  logic [6:0]        immHi,
  input  logic [4:0]        immLoadLo,
  input  logic [4:0]        immStoreLo,
  input  logic [ADDR_W-1:0] rs1Val,
  input  logic [DATA_W-1:0] rs2Val,
  input  logic [DATA_W-1:0] memRdata,
  output logic [$clog2(DATA_W/8)-1:0] addrLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int HALF_W = DATA_W / 2;

  // Address generation
  logic [IMM_W-1:0]  immRaw;
  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] effAddr;

  assign immRaw  = {immHi, immSelStore ? immStoreLo : immLoadLo};
  assign immExt  = {{(ADDR_W-IMM_W){immRaw[IMM_W-1]}}, immRaw};
  assign effAddr = rs1Val + immExt;
  assign addrLow = effAddr[LANE_W-1:0];
  assign memAddr = {effAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  // Store lanes: strobe and replicated data per byte lane
  for (genvar g = 0; g < LANES; g++) begin : gStoreLane
    localparam logic [LANE_W-1:0] LaneIdx = LANE_W'(g);
    logic       beLane;
    logic [7:0] dataLane;

    always_comb begin
      beLane   = 1'b0;
      dataLane = 8'h00;
      if (ctrl.doStore) begin
        unique case (ctrl.size)
          SZ_BYTE: begin
            beLane   = (addrLow == LaneIdx);
            dataLane = rs2Val[7:0];
          end
          SZ_HALF: begin
            beLane   = (addrLow[LANE_W-1] == LaneIdx[LANE_W-1]);
            dataLane = rs2Val[8*(g%2) +: 8];
          end
          SZ_WORD: begin
            beLane   = 1'b1;
            dataLane = rs2Val[8*g +: 8];
          end
          default: begin
            beLane   = 1'b0;
            dataLane = 8'h00;
          end
        endcase
      end
    end

    assign memBe[g]          = beLane;
    assign memWdata[8*g +: 8] = dataLane;
  end

  // Load request tag, aligned with the memory word one cycle later
  logic              pendValid;
  logic [LANE_W-1:0] pendLane;
  accSize_e          pendSize;
  logic              pendZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendLane  <= '0;
      pendSize  <= SZ_NONE;
      pendZero  <= 1'b0;
    end else begin
      pendValid <= ctrl.doLoad;
      if (ctrl.doLoad) begin
        pendLane <= addrLow;
        pendSize <= ctrl.size;
        pendZero <= ctrl.zeroExt;
      end
    end
  end

  // Load extraction
  logic [7:0]        rdByte [LANES];
  logic [7:0]        selByte;
  logic [HALF_W-1:0] selHalf;
  logic [DATA_W-1:0] extWord;

  for (genvar g = 0; g < LANES; g++) begin : gLoadLane
    assign rdByte[g] = memRdata[8*g +: 8];
  end

  assign selByte = rdByte[pendLane];
  assign selHalf = pendLane[LANE_W-1] ? memRdata[DATA_W-1:HALF_W] : memRdata[HALF_W-1:0];

  always_comb begin
    unique case (pendSize)
      SZ_BYTE: extWord = {{(DATA_W-8){!pendZero && selByte[7]}}, selByte};
      SZ_HALF: extWord = {{(DATA_W-HALF_W){!pendZero && selHalf[HALF_W-1]}}, selHalf};
      default: extWord = memRdata;
    endcase
  end

  assign loadValid = pendValid;
  assign loadData  = pendValid ? extWord : '0;

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [6:0]        opcode,
  input  logic [2:0]        funct3,
  input  logic [6:0]        immHi,
  input  logic [4:0]        immLoadLo,
  input  logic [4:0]        immStoreLo,
  input  logic [ADDR_W-1:0] rs1Val,
  input  logic [DATA_W-1:0] rs2Val,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic              misaligned,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData
);

  localparam int LANE_W = $clog2(DATA_W / 8);

  laneCtrl_t         ctrl;
  logic              immSelStore;
  logic [LANE_W-1:0] addrLow;

  lsu_lane_ctrl #(.LANE_W(LANE_W)) u_ctrl (
    .reqValid    (reqValid),
    .opcode      (opcode),
    .funct3      (funct3),
    .addrLow     (addrLow),
    .immSelStore (immSelStore),
    .ctrl        (ctrl)
  );

  lsu_lane_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .immSelStore (immSelStore),
    .immHi       (immHi),
    .immLoadLo   (immLoadLo),
    .immStoreLo  (immStoreLo),
    .rs1Val      (rs1Val),
    .rs2Val      (rs2Val),
    .memRdata    (memRdata),
    .addrLow     (addrLow),
    .memAddr     (memAddr),
    .memBe       (memBe),
    .memWdata    (memWdata),
    .loadValid   (loadValid),
    .loadData    (loadData)
  );

  assign memRe      = ctrl.doLoad;
  assign memWe      = ctrl.doStore;
  assign misaligned = ctrl.misalign;

endmodule

// File: rtl/lsu_lane_checker.sv
module lsu_lane_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [6:0]  opcode,
  input logic [31:0] memAddr,
  input logic        memRe,
  input logic        memWe,
  input logic [3:0]  memBe,
  input logic [31:0] memWdata,
  input logic        misaligned,
  input logic        loadValid,
  input logic [31:0] loadData
);

  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  assert_idle_no_access_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || (opcode != 7'b0000011 && opcode != 7'b0100011))
      |-> (!memRe && !memWe && !misaligned));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> (memAddr[1:0] == 2'b00));

  assert_strobe_present_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memBe) == 1 || memBe == 4'b0011 ||
               memBe == 4'b1100 || memBe == 4'b1111));

  assert_quiet_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWe |-> (memBe == 4'b0000 && memWdata == 32'h0));

  assert_misaligned_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (!memRe && !memWe));

  assert_misaligned_no_result_R5: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |=> !loadValid);

  assert_result_follows_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> loadValid);

  assert_no_spurious_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memRe |=> !loadValid);

  assert_zero_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> (loadData == 32'h0));

endmodule

bind lsu_lane_unit lsu_lane_checker u_lsu_lane_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .opcode     (opcode),
  .memAddr    (memAddr),
  .memRe      (memRe),
  .memWe      (memWe),
  .memBe      (memBe),
  .memWdata   (memWdata),
  .misaligned (misaligned),
  .loadValid  (loadValid),
  .loadData   (loadData)
);

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;

  localparam logic [6:0] OP_RD = 7'b0000011;
  localparam logic [6:0] OP_WR = 7'b0100011;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic [6:0]  immHi;
  logic [4:0]  immLoadLo;
  logic [4:0]  immStoreLo;
  logic [31:0] rs1Val;
  logic [31:0] rs2Val;
  logic [31:0] memRdata;
  logic [31:0] memAddr;
  logic        memRe;
  logic        memWe;
  logic [3:0]  memBe;
  logic [31:0] memWdata;
  logic        misaligned;
  logic        loadValid;
  logic [31:0] loadData;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  lsu_lane_unit u_lsu_lane_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode), .funct3(funct3),
    .immHi(immHi), .immLoadLo(immLoadLo), .immStoreLo(immStoreLo),
    .rs1Val(rs1Val), .rs2Val(rs2Val), .memRdata(memRdata),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memBe(memBe),
    .memWdata(memWdata), .misaligned(misaligned),
    .loadValid(loadValid), .loadData(loadData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] effOf(input logic [31:0] base, input logic [11:0] off);
    return base + {{20{off[11]}}, off};
  endfunction

  function automatic logic [3:0] strobeOf(input logic [2:0] f3, input logic [1:0] lo);
    case (f3[1:0])
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] wdataOf(input logic [2:0] f3, input logic [31:0] v);
    case (f3[1:0])
      2'd0:    return {v[7:0], v[7:0], v[7:0], v[7:0]};
      2'd1:    return {v[15:0], v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] resultOf(input logic [2:0] f3, input logic [1:0] lo,
                                           input logic [31:0] w);
    logic [31:0] s;
    s = w >> (8 * lo);
    case (f3)
      3'd0:    return {{24{s[7]}}, s[7:0]};
      3'd1:    return {{16{s[15]}}, s[15:0]};
      3'd4:    return {24'h0, s[7:0]};
      3'd5:    return {16'h0, s[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic idle();
    reqValid = 1'b0; opcode = 7'h13; funct3 = 3'd0;
    immHi = 7'h0; immLoadLo = 5'h0; immStoreLo = 5'h0;
    rs1Val = 32'h0; rs2Val = 32'h0; memRdata = 32'h0;
  endtask

  task automatic driveReq(input logic [6:0] op, input logic [2:0] f3,
                          input logic [31:0] base, input logic [11:0] off,
                          input logic [31:0] data);
    reqValid = 1'b1; opcode = op; funct3 = f3; rs1Val = base; rs2Val = data;
    immHi = off[11:5];
    if (op == OP_WR) begin immStoreLo = off[4:0]; immLoadLo = 5'h15; end
    else             begin immLoadLo = off[4:0];  immStoreLo = 5'h0A; end
  endtask

  task automatic doStore(input string tag, input logic [2:0] f3,
                         input logic [31:0] base, input logic [11:0] off, input logic [31:0] data);
    logic [31:0] ea;
    ea = effOf(base, off);
    @(negedge clk);
    driveReq(OP_WR, f3, base, off, data);
    #1;
    check({tag, " R1 memWe"}, {31'h0, memWe}, 32'h1);
    check({tag, " R2 memAddr"}, memAddr, {ea[31:2], 2'b00});
    check({tag, " R3 memBe"}, {28'h0, memBe}, {28'h0, strobeOf(f3, ea[1:0])});
    check({tag, " R4 memWdata"}, memWdata, wdataOf(f3, data));
    @(negedge clk);
    idle();
  endtask

  task automatic doLoad(input string tag, input logic [2:0] f3,
                        input logic [31:0] base, input logic [11:0] off, input logic [31:0] word);
    logic [31:0] ea;
    ea = effOf(base, off);
    @(negedge clk);
    driveReq(OP_RD, f3, base, off, 32'h0);
    #1;
    check({tag, " R1 memRe"}, {31'h0, memRe}, 32'h1);
    check({tag, " R2 memAddr"}, memAddr, {ea[31:2], 2'b00});
    @(negedge clk);
    idle();
    memRdata = word;
    #1;
    check({tag, " R6 loadValid"}, {31'h0, loadValid}, 32'h1);
    check({tag, " R7/R8 loadData"}, loadData, resultOf(f3, ea[1:0], word));
    memRdata = 32'h0;
  endtask

  task automatic testReset();
    idle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset R10 loadValid", {31'h0, loadValid}, 32'h0);
    check("reset R10 loadData", loadData, 32'h0);
    check("reset R4 memBe", {28'h0, memBe}, 32'h0);
    rstN = 1'b1;
  endtask

  task automatic testStores();
    for (int k = 0; k < 4; k++)
      doStore($sformatf("sb lane%0d", k), 3'd0, 32'h2000, 12'(k), 32'hCAFE_BEA5);
    doStore("sh low",  3'd1, 32'h2000, 12'h000, 32'h1234_8765);
    doStore("sh high", 3'd1, 32'h2002, 12'h000, 32'h1234_8765);
    doStore("sw",      3'd2, 32'h2000, 12'h010, 32'hDEAD_0F0F);
  endtask

  task automatic testAddressGen();
    doStore("R2 neg offset store", 3'd0, 32'h0000_1001, 12'hFFC, 32'h0000_005A);
    doLoad("R2 neg offset load",   3'd2, 32'h0000_1008, 12'hFF8, 32'h0BAD_F00D);
    doStore("R2 wrap store",       3'd2, 32'h0000_0004, 12'h800, 32'h0000_0001);
  endtask

  task automatic testLoads();
    logic [31:0] w;
    w = 32'h80FF_7F01;
    for (int k = 0; k < 4; k++) begin
      doLoad($sformatf("R7 lb lane%0d", k),  3'd0, 32'h3000, 12'(k), w);
      doLoad($sformatf("R8 lbu lane%0d", k), 3'd4, 32'h3000, 12'(k), w);
    end
    doLoad("R7 lh low",   3'd1, 32'h3000, 12'h000, 32'h7FFF_8001);
    doLoad("R7 lh high",  3'd1, 32'h3000, 12'h002, 32'h9ABC_0123);
    doLoad("R8 lhu low",  3'd5, 32'h3000, 12'h000, 32'h7FFF_8001);
    doLoad("R8 lhu high", 3'd5, 32'h3000, 12'h002, 32'h9ABC_0123);
    doLoad("R7 lw",       3'd2, 32'h3000, 12'h004, 32'h8765_4321);
  endtask

  task automatic testMisaligned();
    logic [6:0]  ops [2];
    logic [2:0]  f3s [5];
    logic [11:0] offs [5];
    ops[0] = OP_RD; ops[1] = OP_WR;
    f3s[0] = 3'd1; offs[0] = 12'd1;
    f3s[1] = 3'd1; offs[1] = 12'd3;
    f3s[2] = 3'd2; offs[2] = 12'd1;
    f3s[3] = 3'd2; offs[3] = 12'd2;
    f3s[4] = 3'd2; offs[4] = 12'd3;
    for (int o = 0; o < 2; o++) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        driveReq(ops[o], f3s[k], 32'h4000, offs[k], 32'hFFFF_FFFF);
        #1;
        check($sformatf("R5 flag op%0d case%0d", o, k), {31'h0, misaligned}, 32'h1);
        check($sformatf("R5 no access op%0d case%0d", o, k), {30'h0, memRe, memWe}, 32'h0);
        check($sformatf("R5 no strobes op%0d case%0d", o, k), {28'h0, memBe}, 32'h0);
        @(negedge clk);
        idle();
        #1;
        check($sformatf("R5 no result op%0d case%0d", o, k), {31'h0, loadValid}, 32'h0);
      end
    end
    @(negedge clk);
    driveReq(OP_RD, 3'd5, 32'h4000, 12'd1, 32'h0);
    #1;
    check("R5 lhu odd flag", {31'h0, misaligned}, 32'h1);
    @(negedge clk);
    idle();
  endtask

  task automatic testUnsupported();
    logic [2:0] badRd [3];
    badRd[0] = 3'd3; badRd[1] = 3'd6; badRd[2] = 3'd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      driveReq(OP_RD, badRd[k], 32'h5000, 12'd1, 32'h0);
      #1;
      check($sformatf("R9 read f3=%0d", badRd[k]), {30'h0, memRe, misaligned}, 32'h0);
      @(negedge clk);
      idle();
      #1;
      check($sformatf("R9 read f3=%0d no result", badRd[k]), {31'h0, loadValid}, 32'h0);
    end
    for (int f = 3; f < 8; f++) begin
      @(negedge clk);
      driveReq(OP_WR, 3'(f), 32'h5000, 12'd1, 32'hFFFF_FFFF);
      #1;
      check($sformatf("R9 write f3=%0d", f), {30'h0, memWe, misaligned}, 32'h0);
      check($sformatf("R9 write f3=%0d strobes", f), {28'h0, memBe}, 32'h0);
    end
    @(negedge clk);
    driveReq(7'b0110011, 3'd2, 32'h5001, 12'd0, 32'hFFFF_FFFF);
    #1;
    check("R1 other opcode", {29'h0, memRe, memWe, misaligned}, 32'h0);
    @(negedge clk);
    driveReq(OP_WR, 3'd2, 32'h5001, 12'd0, 32'hFFFF_FFFF);
    reqValid = 1'b0;
    #1;
    check("R1 reqValid low", {29'h0, memRe, memWe, misaligned}, 32'h0);
    check("R4 idle wdata", memWdata, 32'h0);
    @(negedge clk);
    idle();
  endtask

  task automatic testBackToBack();
    logic [31:0] wA;
    logic [31:0] wB;
    logic [31:0] wC;
    wA = 32'h11F2_3384; wB = 32'hA5B6_C7D8; wC = 32'h0102_8304;
    @(negedge clk);
    driveReq(OP_RD, 3'd0, 32'h6000, 12'd3, 32'h0);
    @(negedge clk);
    memRdata = wA;
    driveReq(OP_RD, 3'd5, 32'h6000, 12'd2, 32'h0);
    #1;
    check("R6 b2b first valid", {31'h0, loadValid}, 32'h1);
    check("R6 b2b first data", loadData, resultOf(3'd0, 2'd3, wA));
    @(negedge clk);
    memRdata = wB;
    driveReq(OP_RD, 3'd4, 32'h6000, 12'd1, 32'h0);
    #1;
    check("R6 b2b second data", loadData, resultOf(3'd5, 2'd2, wB));
    @(negedge clk);
    idle();
    memRdata = wC;
    #1;
    check("R6 b2b third data", loadData, resultOf(3'd4, 2'd1, wC));
    @(negedge clk);
    memRdata = 32'h0;
    #1;
    check("R10 after burst valid", {31'h0, loadValid}, 32'h0);
    check("R10 after burst data", loadData, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testStores();
    testAddressGen();
    testLoads();
    testMisaligned();
    testUnsupported();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule